// File: doc/BRIEF.md
# Two-Wire Register-Access Target with Chip Select

This block is a two-wire serial bus target that gives a host access to a byte-wide register file. It runs on a fast system clock and samples SCL and SDA through synchronizers. It detects START and STOP conditions and shifts bytes in and out on SCL edges. It pulls SDA low through an output enable to acknowledge a byte or to send a zero bit. Register writes go out on a parallel port as single-cycle strobes, and register reads come back combinationally on that port.

The target's own 7-bit bus address is kept in a register at one pointer slot, and the host can rewrite it over the bus. While the active-low chip select is high, the target takes no part in bus traffic. Identical targets on one bus can therefore be given distinct addresses one after another: the chip selects are enabled in turn and each target's address is rewritten while it is the only one selected.

Top module: `smbus_regfile_target`

## Requirements
- R1: The first byte after a START is 7 address bits, MSB first, followed by a direction bit (0 write, 1 read). When the address bits equal the current device address, the target pulls SDA low in the following acknowledge slot.
- R2: In a write, the byte after the address byte loads the register pointer. The next byte is written to the register at that pointer with one reg_we_o strobe.
- R3: Each further byte in the same write goes to pointer+1, pointer+2, and so on, and each such byte is acknowledged.
- R4: A write of the pointer, then a repeated START, then the address with direction 1 makes the target shift out the pointed register MSB first.
- R5: During a read the pointer advances after each byte, and it wraps from 0xFF to 0x00.
- R6: The target releases SDA in the acknowledge slot after each byte it sends. After a host NACK (SDA high in that slot), it drives nothing more.
- R7: A STOP returns the target to idle. Bytes clocked after a STOP and before the next START are not acknowledged and are not written.
- R8: While cs_ni is high, the target never drives SDA, acknowledges nothing and writes nothing.
- R9: The device address is held at pointer DEV_ADDR_PTR (default 0x00), in bits 6:0, with reset value DEV_ADDR_RST (default 0x50). A bus write there changes the address. From then on, only the new address is acknowledged, and a read of that slot returns {0, address}.
- R10: On an address mismatch the target gives no acknowledge, writes nothing and stays idle until the next START.
- R11: A START in any state, including in the middle of a byte, restarts address reception from the first bit.
- R12: After reset, sda_oe_o and reg_we_o are low and the device address is DEV_ADDR_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | High to pull SDA low |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational |

## Verification
The hardest cases to reach from the ports are the ones where a transaction is cut short: a START arriving halfway through a byte, bytes clocked after a STOP with no new START, and a read that runs past pointer 0xFF into the address slot. The bench bit-bangs SCL and SDA, so it can stop a byte after any number of bits or leave out the START. It also rewrites the device address in the middle of the sequence and then checks that the old address gets no response while the new one does.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;
  localparam int BYTE_W  = 8;
  localparam int DADDR_W = 7;
  localparam int BIT_CW  = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK} state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} phase_e;
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_sr[g] <= 1'b1;
        sda_sr[g] <= 1'b1;
      end else if (g == 0) begin
        scl_sr[g] <= scl_i;
        sda_sr[g] <= sda_i;
      end else begin
        scl_sr[g] <= scl_sr[g-1];
        sda_sr[g] <= sda_sr[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_sr[STAGES-1];
      sda_d <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = ~scl_d & scl_o;
  assign scl_fall_o = scl_d & ~scl_o;
  assign start_o    = scl_d & scl_o & sda_d & ~sda_o;
  assign stop_o     = scl_d & scl_o & ~sda_d & sda_o;
endmodule

// File: rtl/smbus_dev_addr_reg.sv
module smbus_dev_addr_reg #(
  parameter int               W   = 7,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_o <= RST;
    else if (we_i) addr_o <= wdata_i;
  end
endmodule

// File: rtl/smbus_regfile_target.sv
module smbus_regfile_target
  import smbus_tgt_pkg::*;
#(
  parameter int                  SYNC_STAGES  = 2,
  parameter logic [DADDR_W-1:0]  DEV_ADDR_RST = 7'h50,
  parameter logic [BYTE_W-1:0]   DEV_ADDR_PTR = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);
  localparam logic [BIT_CW-1:0] FULL     = BIT_CW'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  state_e st_q;
  phase_e ph_q;
  logic [BIT_CW-1:0]  cnt_q;
  logic [BYTE_W-1:0]  rx_q, tx_q, ptr_q;
  logic [DADDR_W-1:0] dev_addr;
  logic drive_q, we_q, rd_q, nack_q;
  logic [BYTE_W-1:0]  rdata;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smbus_dev_addr_reg #(.W(DADDR_W), .RST(DEV_ADDR_RST)) u_daddr (
    .clk_i, .rst_ni,
    .we_i(we_q && ptr_q == DEV_ADDR_PTR),
    .wdata_i(rx_q[DADDR_W-1:0]),
    .addr_o(dev_addr)
  );

  // address slot reads back from the local register
  assign rdata = (ptr_q == DEV_ADDR_PTR) ? {{(BYTE_W-DADDR_W){1'b0}}, dev_addr} : reg_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= PH_ADDR; cnt_q <= '0;
      rx_q <= '0; tx_q <= '0; ptr_q <= '0;
      drive_q <= 1'b0; we_q <= 1'b0; rd_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (cs_ni) begin
        st_q <= ST_IDLE; drive_q <= 1'b0;
      end else if (start_det) begin
        st_q <= ST_RX; ph_q <= PH_ADDR; cnt_q <= '0; drive_q <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE; drive_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise && cnt_q != FULL) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == FULL) begin
              cnt_q <= '0;
              unique case (ph_q)
                PH_ADDR: begin
                  if (rx_q[BYTE_W-1:1] == dev_addr) begin
                    st_q <= ST_ACK; drive_q <= 1'b1; rd_q <= rx_q[0];
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr_q <= rx_q; st_q <= ST_ACK; drive_q <= 1'b1;
                end
                default: begin
                  we_q <= 1'b1; st_q <= ST_ACK; drive_q <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              drive_q <= 1'b0;
              if (ph_q == PH_ADDR && rd_q) begin
                st_q <= ST_TX; tx_q <= rdata; drive_q <= ~rdata[BYTE_W-1]; cnt_q <= '0;
              end else begin
                st_q <= ST_RX;
                if (ph_q == PH_ADDR)     ph_q <= PH_PTR;
                else if (ph_q == PH_PTR) ph_q <= PH_DATA;
                else                     ptr_q <= ptr_q + 1'b1;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == LAST_BIT) begin
                st_q <= ST_HACK; drive_q <= 1'b0; ptr_q <= ptr_q + 1'b1; cnt_q <= '0;
              end else begin
                tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
                drive_q <= ~tx_q[BYTE_W-2];
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          ST_HACK: begin
            if (scl_rise) nack_q <= sda_s;
            else if (scl_fall) begin
              if (!nack_q) begin
                st_q <= ST_TX; tx_q <= rdata; drive_q <= ~rdata[BYTE_W-1];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = drive_q & ~cs_ni;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = rx_q;
  assign reg_we_o    = we_q;
endmodule

// File: rtl/smbus_regfile_target_chk.sv
module smbus_regfile_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic idle_i
);
  p_we_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_cs_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !reg_we_o);

  p_start_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  p_stop_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> idle_i);

  // SDA only changes while SCL is low
  p_oe_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s) && !cs_ni && !$past(cs_ni) &&
     !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o));
endmodule

bind smbus_regfile_target smbus_regfile_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sda_oe_o(sda_oe_o),
  .reg_we_o(reg_we_o), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .idle_i(st_q == smbus_tgt_pkg::ST_IDLE)
);

// File: tb/sim_smbus_regfile_target.sv
module sim_smbus_regfile_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe_o, reg_we_o;
  logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
  logic sda_bus;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [6:0] exp_dev;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe_o;

  smbus_regfile_target u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_we_o(reg_we_o), .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = mem[reg_addr_o];
  always_ff @(posedge clk) if (reg_we_o) mem[reg_addr_o] <= reg_wdata_o;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every clock: no drive or write with chip select high (R8)
  always @(negedge clk) if (rst_ni && cs_ni) begin
    chk(!sda_oe_o && !reg_we_o, "R8 per-clock", {sda_oe_o, reg_we_o}, 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_h = 1'b1; wq(Q); scl_h = 1'b1; wq(Q); sda_h = 1'b0; wq(Q); scl_h = 1'b0; wq(Q);
  endtask
  task automatic bus_stop;
    sda_h = 1'b0; wq(Q); scl_h = 1'b1; wq(Q); sda_h = 1'b1; wq(Q);
  endtask
  task automatic put_bit(input bit b);
    sda_h = b; wq(Q); scl_h = 1'b1; wq(2*Q); scl_h = 1'b0; wq(Q);
  endtask
  task automatic get_bit(output bit b);
    sda_h = 1'b1; wq(Q); scl_h = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_h = 1'b0; wq(Q);
  endtask
  task automatic wr_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b); ack = ~b;
  endtask
  task automatic rd_byte(input bit nack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    sda_h = nack; wq(Q); scl_h = 1'b1; wq(Q);
    chk(!sda_oe_o, "R6 released in host ack slot", sda_oe_o, 0);
    wq(Q); scl_h = 1'b0; wq(Q);
  endtask

  // model: write transaction, returns ack of every byte
  task automatic host_write(input logic [6:0] da, input logic [7:0] ptr,
                            input logic [7:0] d [], input string req);
    bit a;
    logic [7:0] p = ptr;
    bus_start; wr_byte({da, 1'b0}, a);
    chk(a == (da == exp_dev && !cs_ni), {req, " addr ack"}, a, da == exp_dev && !cs_ni);
    if (a) begin
      wr_byte(ptr, a); chk(a, {req, " ptr ack"}, a, 1);
      foreach (d[i]) begin
        wr_byte(d[i], a); chk(a, {req, " data ack"}, a, 1);
        exp_mem[p] = d[i];
        if (p == 8'h00) exp_dev = d[i][6:0];
        p++;
      end
    end
    bus_stop;
  endtask

  task automatic host_read(input logic [7:0] ptr, input int n, input string req);
    bit a;
    logic [7:0] v, e, p = ptr;
    bus_start; wr_byte({exp_dev, 1'b0}, a); wr_byte(ptr, a);
    bus_start; wr_byte({exp_dev, 1'b1}, a);
    chk(a, {req, " read addr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, v);
      e = (p == 8'h00) ? {1'b0, exp_dev} : exp_mem[p];
      chk(v == e, req, v, e);
      p++;
    end
    wq(2*Q);
    chk(!sda_oe_o, "R6 silent after NACK", sda_oe_o, 0);
    bus_stop;
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
    exp_dev = 7'h50;
    wq(4); rst_ni = 1'b1; wq(4);
    chk(!sda_oe_o && !reg_we_o, "R12 reset outputs", {sda_oe_o, reg_we_o}, 0);

    host_write(7'h50, 8'h10, '{8'hA1, 8'hB2, 8'hC3}, "R1 R2 R3 write burst");
    chk(mem[8'h10] == 8'hA1, "R2 first data", mem[8'h10], 8'hA1);
    chk(mem[8'h12] == 8'hC3, "R3 incremented data", mem[8'h12], 8'hC3);

    host_read(8'h10, 3, "R4 read burst");
    host_read(8'hFE, 3, "R5 wrap read with R12 reset address");

    // R10 mismatch
    bus_start; wr_byte({7'h33, 1'b0}, a);
    chk(!a, "R10 mismatch no ack", a, 0);
    wr_byte(8'h20, a); chk(!a, "R10 no ack after mismatch", a, 0);
    wr_byte(8'h77, a); bus_stop;
    chk(mem[8'h20] == exp_mem[8'h20], "R10 no write", mem[8'h20], exp_mem[8'h20]);

    // R7 bytes after STOP
    host_write(7'h50, 8'h30, '{8'h44}, "R7 write");
    wr_byte(8'hA0, a); chk(!a, "R7 no ack after stop", a, 0);
    wr_byte(8'h55, a); wq(Q);
    chk(mem[8'h31] == exp_mem[8'h31], "R7 no write after stop", mem[8'h31], exp_mem[8'h31]);
    bus_stop;

    // R11 START mid-byte
    bus_start; put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    host_write(7'h50, 8'h40, '{8'h66}, "R11 restart");
    chk(mem[8'h40] == 8'h66, "R11 write after restart", mem[8'h40], 8'h66);

    // R8 chip select high
    cs_ni = 1'b1;
    host_write(7'h50, 8'h50, '{8'h77}, "R8 deselected");
    chk(mem[8'h50] == exp_mem[8'h50], "R8 no write", mem[8'h50], exp_mem[8'h50]);
    cs_ni = 1'b0; wq(Q);

    // R9 address rewrite
    host_write(7'h50, 8'h00, '{8'h2A}, "R9 rewrite");
    bus_start; wr_byte({7'h50, 1'b0}, a); bus_stop;
    chk(!a, "R9 old address ignored", a, 0);
    host_write(7'h2A, 8'h60, '{8'h5A}, "R9 new address");
    chk(mem[8'h60] == 8'h5A, "R9 write at new address", mem[8'h60], 8'h5A);
    host_read(8'h00, 1, "R9 address readback");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule